// File: doc/BRIEF.md
# IO Subchannel End Status and Halt Decision

This block records how a data transfer on one IO subchannel ended and decides whether the attached device must be halted. It watches the end-of-record pulse from the device controller and the byte-count-exhausted pulse from the channel. Their relative order tells it whether the transfer length matched the device's record. It also latches the error strobes that the transfer and command-fetch paths raise.

Each latched condition appears as one bit of a six-bit status word. The length-error severity is taken from two flags of the current command: suppress-length-error and halt-on-transmission-error. Transmission errors are weighed by the halt flag alone. Some bits are cleared only by a successful start instruction, while the others also clear on a successful halt instruction. A qualifying condition produces a one-cycle halt request for the device controller.

Top module: `io_subch_status`

## Requirements
- R1: While rst_ni is low and after its release, status_o is 0 and halt_req_o is 0.
- R2: The first chan_end_i after a clear, arriving when cnt_done_i has not been seen (neither earlier nor in the same cycle), sets status_o[0] (incorrect length) in the next cycle.
- R3: If cnt_done_i arrives strictly before the first chan_end_i, that chan_end_i sets status_o[0]. If both arrive in the same cycle, status_o[0] stays 0. cnt_done_i alone, a cnt_done_i after chan_end_i, and any later chan_end_i before the next successful start never set the bit or request a halt.
- R4: Incorrect length is recorded whatever sil_i is. It raises halt_req_o in the next cycle only when, in the cycle of the evaluating chan_end_i, sil_i is 0 and hte_i is 1.
- R5: data_err_i sets status_o[1] in the next cycle and raises halt_req_o in the next cycle when hte_i is 1.
- R6: xfer_mem_err_i sets status_o[2] in the next cycle and raises halt_req_o in the next cycle when hte_i is 1.
- R7: addr_err_i sets status_o[3] in the next cycle and never requests a halt.
- R8: fetch_mem_err_i sets status_o[4] in the next cycle and never requests a halt.
- R9: status_o[5] (control error) is set in the cycle after a fetch_i with fetch_tic_i high whose previous fetch_i also had fetch_tic_i high. A fetch with fetch_tic_i low, or a successful start, breaks the pair. A successful halt does not. fetch_tic_i is ignored without fetch_i.
- R10: start_i with ok_i clears all six status bits and the length tracking. halt_i with ok_i clears only bits 5:3. With ok_i low, neither instruction changes anything.
- R11: Status bits are sticky until cleared as in R10. A set strobe in the same cycle as a clear leaves its bit set.
- R12: halt_req_o is high for exactly the cycle after each qualifying cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_end_i | input | 1 | End-of-record pulse from the device controller |
| cnt_done_i | input | 1 | Byte count reached zero pulse |
| data_err_i | input | 1 | Data parity error or overrun strobe |
| xfer_mem_err_i | input | 1 | Memory parity error during transfer |
| addr_err_i | input | 1 | Nonexistent address during chaining or transfer |
| fetch_mem_err_i | input | 1 | Memory parity error on command fetch |
| fetch_i | input | 1 | Command fetch completed |
| fetch_tic_i | input | 1 | Fetched command is a transfer-in-channel |
| sil_i | input | 1 | Suppress-length-error flag of current command |
| hte_i | input | 1 | Halt-on-transmission-error flag of current command |
| start_i | input | 1 | Start instruction pulse |
| halt_i | input | 1 | Halt instruction pulse |
| ok_i | input | 1 | Instruction accepted successfully |
| status_o | output | 6 | [0] length, [1] data, [2] transfer memory, [3] address, [4] fetch memory, [5] control error |
| halt_req_o | output | 1 | One-cycle device halt request |

## Verification
Each status bit and the halt request is registered once, so every result is due exactly one clock after the strobe cycle. The bench changes inputs at a falling edge and reads outputs at the following falling edge, where that single register has just updated. The stability of sticky bits and the fall of halt_req_o are read one further falling edge later. The length logic is swept over all four arrival orders of end-of-record and count-done against every combination of the two severity flags.

// File: rtl/io_subch_pkg.sv
package io_subch_pkg;
  localparam int unsigned STS_W    = 6;
  localparam int unsigned IDX_LEN  = 0;
  localparam int unsigned IDX_DATA = 1;
  localparam int unsigned IDX_XMEM = 2;
  localparam int unsigned IDX_ADDR = 3;
  localparam int unsigned IDX_FMEM = 4;
  localparam int unsigned IDX_CTRL = 5;
  // bits at or above this index also clear on a successful halt
  localparam int unsigned HALT_CLR_LO = IDX_ADDR;
endpackage

// File: rtl/io_len_track.sv
module io_len_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic chan_end_i,
  input  logic cnt_done_i,
  output logic il_evt_o
);
  logic seen_ce_q, seen_cd_q;
  logic first_ce;

  assign first_ce = chan_end_i & ~seen_ce_q;
  // no length error only when count done lands in the same cycle as end
  assign il_evt_o = first_ce & ~(cnt_done_i & ~seen_cd_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_ce_q <= 1'b0;
      seen_cd_q <= 1'b0;
    end else if (clr_i) begin
      seen_ce_q <= 1'b0;
      seen_cd_q <= 1'b0;
    end else begin
      seen_ce_q <= seen_ce_q | chan_end_i;
      seen_cd_q <= seen_cd_q | cnt_done_i;
    end
  end
endmodule

// File: rtl/io_tic_detect.sv
module io_tic_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fetch_i,
  input  logic tic_i,
  output logic dbl_o
);
  logic prev_tic_q;

  assign dbl_o = fetch_i & tic_i & prev_tic_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_tic_q <= 1'b0;
    else if (clr_i)   prev_tic_q <= 1'b0;
    else if (fetch_i) prev_tic_q <= tic_i;
  end
endmodule

// File: rtl/io_sticky_bits.sv
module io_sticky_bits #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q;
    // set wins over clear so an event in the clearing cycle is kept
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[b] | (q & ~clr_i[b]);
    end
    assign q_o[b] = q;
  end
endmodule

// File: rtl/io_subch_status.sv
module io_subch_status
  import io_subch_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_end_i,
  input  logic             cnt_done_i,
  input  logic             data_err_i,
  input  logic             xfer_mem_err_i,
  input  logic             addr_err_i,
  input  logic             fetch_mem_err_i,
  input  logic             fetch_i,
  input  logic             fetch_tic_i,
  input  logic             sil_i,
  input  logic             hte_i,
  input  logic             start_i,
  input  logic             halt_i,
  input  logic             ok_i,
  output logic [STS_W-1:0] status_o,
  output logic             halt_req_o
);
  logic start_ok, halt_ok;
  logic il_evt, ctrl_evt;
  logic [STS_W-1:0] set_v, clr_v;
  logic halt_d, halt_q;

  assign start_ok = start_i & ok_i;
  assign halt_ok  = halt_i & ok_i;

  io_len_track u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_ok),
    .chan_end_i(chan_end_i),
    .cnt_done_i(cnt_done_i),
    .il_evt_o  (il_evt)
  );

  io_tic_detect u_tic (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .fetch_i(fetch_i),
    .tic_i  (fetch_tic_i),
    .dbl_o  (ctrl_evt)
  );

  always_comb begin
    set_v           = '0;
    set_v[IDX_LEN]  = il_evt;
    set_v[IDX_DATA] = data_err_i;
    set_v[IDX_XMEM] = xfer_mem_err_i;
    set_v[IDX_ADDR] = addr_err_i;
    set_v[IDX_FMEM] = fetch_mem_err_i;
    set_v[IDX_CTRL] = ctrl_evt;
  end

  for (genvar b = 0; b < STS_W; b++) begin : g_clr
    if (b >= HALT_CLR_LO) begin : g_both
      assign clr_v[b] = start_ok | halt_ok;
    end else begin : g_start
      assign clr_v[b] = start_ok;
    end
  end

  io_sticky_bits #(.W(STS_W)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_v),
    .clr_i (clr_v),
    .q_o   (status_o)
  );

  assign halt_d = hte_i & ((il_evt & ~sil_i) | data_err_i | xfer_mem_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= halt_d;
  end

  assign halt_req_o = halt_q;
endmodule

// File: rtl/io_subch_status_chk.sv
module io_subch_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_end_i,
  input logic       data_err_i,
  input logic       xfer_mem_err_i,
  input logic       addr_err_i,
  input logic       fetch_mem_err_i,
  input logic       fetch_i,
  input logic       fetch_tic_i,
  input logic       sil_i,
  input logic       hte_i,
  input logic       start_i,
  input logic       halt_i,
  input logic       ok_i,
  input logic [5:0] status_o,
  input logic       halt_req_o
);
  a_r4_halt_needs_hte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> $past(hte_i));

  a_r4_sil_no_len_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_end_i && sil_i && !data_err_i && !xfer_mem_err_i) |=> !halt_req_o);

  a_r5_data_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_err_i |=> status_o[1]);

  a_r6_xmem_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_mem_err_i |=> status_o[2]);

  a_r7_addr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_i |=> status_o[3]);

  a_r8_fmem_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_mem_err_i |=> status_o[4]);

  a_r9_ctrl_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> $past(fetch_i && fetch_tic_i));

  a_r10_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ok_i && !chan_end_i && !data_err_i && !xfer_mem_err_i &&
     !addr_err_i && !fetch_mem_err_i && !fetch_i) |=> (status_o == 6'd0));

  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ok_i && (start_i || halt_i))) |=> ((status_o & $past(status_o)) == $past(status_o)));

  a_r12_halt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> $past(data_err_i || xfer_mem_err_i || chan_end_i));
endmodule

bind io_subch_status io_subch_status_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .chan_end_i     (chan_end_i),
  .data_err_i     (data_err_i),
  .xfer_mem_err_i (xfer_mem_err_i),
  .addr_err_i     (addr_err_i),
  .fetch_mem_err_i(fetch_mem_err_i),
  .fetch_i        (fetch_i),
  .fetch_tic_i    (fetch_tic_i),
  .sil_i          (sil_i),
  .hte_i          (hte_i),
  .start_i        (start_i),
  .halt_i         (halt_i),
  .ok_i           (ok_i),
  .status_o       (status_o),
  .halt_req_o     (halt_req_o)
);

// File: tb/io_subch_status_test.sv
module io_subch_status_test;
  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic rst_ni;
  logic chan_end_i, cnt_done_i, data_err_i, xfer_mem_err_i, addr_err_i;
  logic fetch_mem_err_i, fetch_i, fetch_tic_i, sil_i, hte_i;
  logic start_i, halt_i, ok_i;
  logic [5:0] status_o;
  logic halt_req_o;

  int n_chk  = 0;
  int n_fail = 0;

  io_subch_status uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .chan_end_i(chan_end_i), .cnt_done_i(cnt_done_i),
    .data_err_i(data_err_i), .xfer_mem_err_i(xfer_mem_err_i), .addr_err_i(addr_err_i),
    .fetch_mem_err_i(fetch_mem_err_i), .fetch_i(fetch_i), .fetch_tic_i(fetch_tic_i),
    .sil_i(sil_i), .hte_i(hte_i), .start_i(start_i), .halt_i(halt_i), .ok_i(ok_i),
    .status_o(status_o), .halt_req_o(halt_req_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // advance to the next falling edge and drop all strobes
  task automatic cyc();
    @(negedge clk_i);
    chan_end_i = 0; cnt_done_i = 0; data_err_i = 0; xfer_mem_err_i = 0;
    addr_err_i = 0; fetch_mem_err_i = 0; fetch_i = 0; fetch_tic_i = 0;
    start_i = 0; halt_i = 0; ok_i = 0;
  endtask

  task automatic clr_all();
    start_i = 1; ok_i = 1; cyc();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic exp_halt;
    rst_ni = 0; sil_i = 0; hte_i = 0;
    chan_end_i = 0; cnt_done_i = 0; data_err_i = 0; xfer_mem_err_i = 0;
    addr_err_i = 0; fetch_mem_err_i = 0; fetch_i = 0; fetch_tic_i = 0;
    start_i = 0; halt_i = 0; ok_i = 0;
    repeat (3) @(negedge clk_i);
    chk("R1", "status in reset", status_o, 0);
    chk("R1", "halt in reset", halt_req_o, 0);
    rst_ni = 1;
    cyc();
    chk("R1", "status after reset", status_o, 0);
    chk("R1", "halt after reset", halt_req_o, 0);

    // length sweep: order x sil x hte
    for (int o = 0; o < 4; o++) begin
      for (int s = 0; s < 2; s++) begin
        for (int h = 0; h < 2; h++) begin
          sil_i = s[0]; hte_i = h[0];
          clr_all();
          exp_halt = (s == 0) && (h == 1);
          case (o)
            0: begin
              cnt_done_i = 1; cyc();
              chk("R3", "count done alone", status_o[0], 0);
              chk("R3", "count done alone halt", halt_req_o, 0);
              chan_end_i = 1; cyc();
              chk("R3", "cd before ce length", status_o[0], 1);
              chk("R4", "cd before ce halt", halt_req_o, exp_halt);
            end
            1: begin
              chan_end_i = 1; cnt_done_i = 1; cyc();
              chk("R3", "same cycle length", status_o[0], 0);
              chk("R3", "same cycle halt", halt_req_o, 0);
            end
            2: begin
              chan_end_i = 1; cyc();
              chk("R2", "ce only length", status_o[0], 1);
              chk("R4", "ce only halt", halt_req_o, exp_halt);
            end
            default: begin
              chan_end_i = 1; cyc();
              chk("R2", "ce then cd length", status_o[0], 1);
              chk("R4", "ce then cd halt", halt_req_o, exp_halt);
              cnt_done_i = 1; cyc();
              chk("R3", "late cd halt", halt_req_o, 0);
            end
          endcase
          cyc();
          chk("R12", "halt pulse ends", halt_req_o, 0);
          chan_end_i = 1; cyc();
          chk("R3", "second ce halt", halt_req_o, 0);
          chk("R11", "length bit held", status_o[0], (o != 1));
        end
      end
    end

    // error strobes x hte
    for (int e = 0; e < 4; e++) begin
      for (int h = 0; h < 2; h++) begin
        sil_i = 0; hte_i = h[0];
        clr_all();
        case (e)
          0: data_err_i = 1;
          1: xfer_mem_err_i = 1;
          2: addr_err_i = 1;
          default: fetch_mem_err_i = 1;
        endcase
        cyc();
        chk(e == 0 ? "R5" : e == 1 ? "R6" : e == 2 ? "R7" : "R8", "error bit",
            status_o, 32'd1 << (e + 1));
        chk(e == 0 ? "R5" : e == 1 ? "R6" : e == 2 ? "R7" : "R8", "error halt",
            halt_req_o, (e < 2) && (h == 1));
        cyc();
        chk("R11", "error bit sticky", status_o, 32'd1 << (e + 1));
        chk("R12", "error halt ends", halt_req_o, 0);
      end
    end

    // two TICs in a row
    hte_i = 0;
    clr_all();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R9", "single tic", status_o[5], 0);
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R9", "double tic", status_o[5], 1);
    clr_all();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    fetch_i = 1; fetch_tic_i = 0; cyc();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R9", "tic split by non-tic", status_o[5], 0);
    fetch_tic_i = 1; cyc();
    chk("R9", "tic flag without fetch", status_o[5], 0);
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R9", "tic after ignored flag", status_o[5], 1);
    clr_all();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    clr_all();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R9", "start breaks tic pair", status_o[5], 0);
    halt_i = 1; ok_i = 1; cyc();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R9", "halt keeps tic pair", status_o[5], 1);

    // clearing behaviour with every bit set
    clr_all();
    chan_end_i = 1; data_err_i = 1; xfer_mem_err_i = 1; addr_err_i = 1;
    fetch_mem_err_i = 1; fetch_i = 1; fetch_tic_i = 1; cyc();
    fetch_i = 1; fetch_tic_i = 1; cyc();
    chk("R11", "all bits set", status_o, 6'h3f);
    halt_i = 1; ok_i = 0; cyc();
    chk("R10", "failed halt", status_o, 6'h3f);
    start_i = 1; ok_i = 0; cyc();
    chk("R10", "failed start", status_o, 6'h3f);
    halt_i = 1; ok_i = 1; cyc();
    chk("R10", "halt clears upper", status_o, 6'h07);
    clr_all();
    chk("R10", "start clears all", status_o, 0);

    // set wins over clear
    addr_err_i = 1; halt_i = 1; ok_i = 1; cyc();
    chk("R11", "set beats halt clear", status_o, 6'h08);
    data_err_i = 1; start_i = 1; ok_i = 1; cyc();
    chk("R11", "set beats start clear", status_o, 6'h02);

    // start clears length tracking
    clr_all();
    cnt_done_i = 1; cyc();
    clr_all();
    chan_end_i = 1; cnt_done_i = 1; cyc();
    chk("R10", "tracking cleared by start", status_o[0], 0);

    cyc();
    summary();
    $finish;
  end
endmodule